// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a register bus and a byte-level I2C transaction engine. Software loads an address or data byte into a byte buffer, sets one or more command bits in a single write, and the sequencer turns that write into an ordered chain of bus steps. Each step goes to the transaction engine through a request/done handshake. The steps are an addressed START, a byte transmit, a byte receive and a STOP. The engine returns ACK/NAK status or a received byte. The results appear as write-1-to-clear interrupt status bits, a received byte in the buffer, and a 4-bit state code that software reads from the command register.

The sequencer has six states. F_IDLE waits for an accepted command write, or for a pending receive whose receive-done flag has been cleared. F_PICK chooses the next pending step in priority order START, TX, RX, STOP. It returns to F_IDLE when nothing is left, and that return marks the end of a sequence. F_START, F_TX, F_RX and F_STOP each hold a request to the engine until done comes back, then return to F_PICK. There are two shortcuts. An abnormal STOP goes from F_PICK straight to F_IDLE without a bus step. A NAKed START goes from F_START straight to F_IDLE.

A receive is never issued while the receive-done flag is set. It stays pending in the command register and starts on its own once software clears the flag. At the end of every sequence the status is reduced to the enabled bits, and the interrupt line reflects what remains.

Top module: `i2cm_cmd_seq`

## Requirements
- R1: A write to the command register (address 3) is accepted only when control bit 0 (master enable) is set and the sequencer is in F_IDLE. An accepted write replaces command bits [15:0]. The command bits are: bit0 START, bit1 TX, bit3 RX, bit4 RX-last, bit5 STOP. A write that is not accepted leaves the command register unchanged and issues no bus step.
- R2: Pending steps run one at a time in the order START, TX, RX, STOP. Each step clears its own command bit when it finishes.
- R3: START issues bus op 0 with byte buffer bits [7:0] as the address byte (bit 0 is the direction). The state code becomes 0xA if state bit 3 was set, otherwise 0x9. On ACK, START sets status bit 0, clears command bits 0 and 1, and moves the state to 0x8. On NAK, START sets status bit 1, clears command bits [5:0], returns the state to 0x0 and skips the remaining steps.
- R4: TX issues bus op 1 with buffer bits [7:0], with state code 0xC. ACK sets status bit 0 and NAK sets status bit 1. Afterwards the state is 0x8 and command bit 1 is cleared.
- R5: RX issues bus op 2 with state code 0xE and with the last flag equal to command bit 4, so that the engine NAKs the final byte. The returned byte goes into buffer bits [15:8] and status bit 2 is set. Command bits 3 and 4 are cleared and the state becomes 0x8.
- R6: While status bit 2 is set, a pending RX is not issued. When the bit is clear and RX or RX-last is pending, the receive starts without a new command write.
- R7: STOP with state bit 3 clear sets status bit 5 and makes no bus step. Otherwise STOP issues bus op 3 with state code 0xB and sets status bit 4. In both cases the state then returns to 0x0 and command bit 5 is cleared.
- R8: Status bits [14:0] (address 2) are write-1-to-clear, and the enable register (address 1) holds 15 bits. When a sequence ends, the status is ANDed with the enable mask, and the interrupt output asserts if any bit remains.
- R9: The interrupt output falls when the status register becomes all zero.
- R10: A command register read shows the state code in bits [22:19] and the bus-busy input in bit 16. A buffer write (address 4) loads bits [7:0]. Control is at address 0.
- R11: A bus request stays asserted with a stable op until done is returned, and at most one step is outstanding.
- R12: After reset, control, enable, status, command and buffer read as zero, the state is 0x0, and neither request nor interrupt is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational |
| bus_busy | input | 1 | Bus busy indication from the line monitor |
| txn_req | output | 1 | Bus step request |
| txn_op | output | 2 | Step: 0 START, 1 write byte, 2 read byte, 3 STOP |
| txn_byte | output | 8 | Address or data byte for the step |
| txn_last | output | 1 | Read step must be answered with NAK |
| txn_done | input | 1 | Step finished, one-cycle pulse |
| txn_ack | input | 1 | Acknowledge seen for START or write step |
| txn_rdata | input | 8 | Byte returned by a read step |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after these corner cases:

- **Receive waits for the cleared flag.** A receive is written while receive-done is still set, and then the flag is cleared. A design that ignores the flag would overwrite the unread byte. A design that needs a fresh command write would leave the receive stuck after the clear.
- **Repeated START.** A START is issued from the active state. A design that loses track of state bit 3 would report 0x9 instead of 0xA.
- **STOP with nothing open.** A STOP is issued with no transfer open. A design that does not check the state would drive a bus step instead of flagging an abnormal stop.
- **START not acknowledged.** The START is NAKed while other commands are pending. A design that does not skip the rest would go on to transmit and receive on a dead bus.
- **Receive-done masked off.** The receive-done bit is left out of the enable mask. The end-of-sequence mask then drops the flag and lets a held receive run at once.

Random command mixes and ACK patterns are checked against a bench model of the step order.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // Bus step encodings presented on txn_op
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } txn_op_e;

    // Sequencer states
    typedef enum logic [2:0] {
        F_IDLE  = 3'd0,
        F_PICK  = 3'd1,
        F_START = 3'd2,
        F_TX    = 3'd3,
        F_RX    = 3'd4,
        F_STOP  = 3'd5
    } seq_state_e;

    // State codes visible to software (bit 3 means "transfer open")
    localparam logic [3:0] SC_IDLE    = 4'h0;
    localparam logic [3:0] SC_ACTIVE  = 4'h8;
    localparam logic [3:0] SC_START   = 4'h9;
    localparam logic [3:0] SC_RESTART = 4'hA;
    localparam logic [3:0] SC_STOP    = 4'hB;
    localparam logic [3:0] SC_TXD     = 4'hC;
    localparam logic [3:0] SC_RXD     = 4'hE;

    // Command bit positions
    localparam int CB_START = 0;
    localparam int CB_TX    = 1;
    localparam int CB_RX    = 3;
    localparam int CB_LAST  = 4;
    localparam int CB_STOP  = 5;
    localparam int CB_W     = 6;

    // Status bit positions
    localparam int ST_ACK    = 0;
    localparam int ST_NAK    = 1;
    localparam int ST_RXDONE = 2;
    localparam int ST_STOP   = 4;
    localparam int ST_ABN    = 5;

    // Register addresses
    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_IEN  = 3'd1;
    localparam logic [2:0] RA_STS  = 3'd2;
    localparam logic [2:0] RA_CMD  = 3'd3;
    localparam logic [2:0] RA_BUF  = 3'd4;

endpackage

// File: rtl/i2cm_seq_fsm.sv
module i2cm_seq_fsm
    import i2cm_pkg::*;
#(
    parameter int STS_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              c_start,
    input  logic              c_tx,
    input  logic              c_rx,
    input  logic              c_last,
    input  logic              c_stop,
    input  logic              rx_done_flag,
    input  logic              txn_done,
    input  logic              txn_ack,
    output logic              txn_req,
    output txn_op_e           txn_op,
    output logic [CB_W-1:0]   cmd_clr,
    output logic [STS_W-1:0]  sts_set,
    output logic              rx_load,
    output logic              seq_end,
    output logic              seq_idle,
    output logic [3:0]        state_code
);

    seq_state_e cur_q, nxt;
    logic [3:0] code_q, code_nxt;
    logic       rx_pend;

    assign rx_pend = c_rx | c_last;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= F_IDLE;
            code_q <= SC_IDLE;
        end else begin
            cur_q  <= nxt;
            code_q <= code_nxt;
        end
    end

    // Transition and output process
    always_comb begin
        nxt      = cur_q;
        code_nxt = code_q;
        cmd_clr  = '0;
        sts_set  = '0;
        rx_load  = 1'b0;
        seq_end  = 1'b0;
        txn_req  = 1'b0;
        txn_op   = OP_START;
        unique case (cur_q)
            F_IDLE: begin
                if (go || (rx_pend && !rx_done_flag)) begin
                    nxt = F_PICK;
                end
            end
            F_PICK: begin
                if (c_start) begin
                    nxt      = F_START;
                    code_nxt = code_q[3] ? SC_RESTART : SC_START;
                end else if (c_tx) begin
                    nxt      = F_TX;
                    code_nxt = SC_TXD;
                end else if (rx_pend && !rx_done_flag) begin
                    nxt      = F_RX;
                    code_nxt = SC_RXD;
                end else if (c_stop) begin
                    if (code_q[3]) begin
                        nxt      = F_STOP;
                        code_nxt = SC_STOP;
                    end else begin
                        sts_set[ST_ABN]  = 1'b1;
                        cmd_clr[CB_STOP] = 1'b1;
                        code_nxt         = SC_IDLE;
                        nxt              = F_IDLE;
                        seq_end          = 1'b1;
                    end
                end else begin
                    nxt     = F_IDLE;
                    seq_end = 1'b1;
                end
            end
            F_START: begin
                txn_req = 1'b1;
                txn_op  = OP_START;
                if (txn_done) begin
                    if (txn_ack) begin
                        sts_set[ST_ACK]   = 1'b1;
                        cmd_clr[CB_START] = 1'b1;
                        cmd_clr[CB_TX]    = 1'b1;
                        code_nxt          = SC_ACTIVE;
                        nxt               = F_PICK;
                    end else begin
                        sts_set[ST_NAK] = 1'b1;
                        cmd_clr         = '1;
                        code_nxt        = SC_IDLE;
                        nxt             = F_IDLE;
                        seq_end         = 1'b1;
                    end
                end
            end
            F_TX: begin
                txn_req = 1'b1;
                txn_op  = OP_WRITE;
                if (txn_done) begin
                    if (txn_ack) sts_set[ST_ACK] = 1'b1;
                    else         sts_set[ST_NAK] = 1'b1;
                    cmd_clr[CB_TX] = 1'b1;
                    code_nxt       = SC_ACTIVE;
                    nxt            = F_PICK;
                end
            end
            F_RX: begin
                txn_req = 1'b1;
                txn_op  = OP_READ;
                if (txn_done) begin
                    rx_load             = 1'b1;
                    sts_set[ST_RXDONE]  = 1'b1;
                    cmd_clr[CB_RX]      = 1'b1;
                    cmd_clr[CB_LAST]    = 1'b1;
                    code_nxt            = SC_ACTIVE;
                    nxt                 = F_PICK;
                end
            end
            F_STOP: begin
                txn_req = 1'b1;
                txn_op  = OP_STOP;
                if (txn_done) begin
                    sts_set[ST_STOP] = 1'b1;
                    cmd_clr[CB_STOP] = 1'b1;
                    code_nxt         = SC_IDLE;
                    nxt              = F_PICK;
                end
            end
            default: begin
                nxt      = F_IDLE;
                code_nxt = SC_IDLE;
            end
        endcase
    end

    assign seq_idle   = (cur_q == F_IDLE);
    assign state_code = code_q;

    // R11: request held with a stable op until done
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && !txn_done) |=> (txn_req && $stable(txn_op)));

    // R6: a read step never starts while receive-done is set
    p_rx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(txn_req) && txn_op == OP_READ) |-> !rx_done_flag);

    // R2: a write step never starts with START still pending
    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(txn_req) && txn_op == OP_WRITE) |-> !c_start);

    // R7: a finished STOP leaves the state code idle
    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && txn_op == OP_STOP && txn_done) |=> (state_code == SC_IDLE));

endmodule

// File: rtl/i2cm_irq.sv
module i2cm_irq #(
    parameter int STS_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_we,
    input  logic             sts_we,
    input  logic [STS_W-1:0] wdata,
    input  logic [STS_W-1:0] sts_set,
    input  logic             seq_end,
    output logic [STS_W-1:0] ien,
    output logic [STS_W-1:0] status,
    output logic             irq
);

    logic [STS_W-1:0] ien_q, sts_q, sts_nxt, clr;
    logic             irq_q, irq_nxt;

    always_comb begin
        clr     = sts_we ? wdata : '0;
        sts_nxt = (sts_q | sts_set) & ~clr;
        if (seq_end) begin
            sts_nxt = sts_nxt & ien_q;
        end
        if (seq_end) begin
            irq_nxt = |sts_nxt;
        end else if (sts_nxt == '0) begin
            irq_nxt = 1'b0;
        end else begin
            irq_nxt = irq_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
            sts_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (ien_we) ien_q <= wdata;
            sts_q <= sts_nxt;
            irq_q <= irq_nxt;
        end
    end

    assign ien    = ien_q;
    assign status = sts_q;
    assign irq    = irq_q;

    // R9: interrupt is never high with an empty status
    p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    // R8: after a sequence ends only enabled bits survive
    p_mask_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end && !ien_we) |=> ((status & ~ien) == '0));

endmodule

// File: rtl/i2cm_cmd_seq.sv
module i2cm_cmd_seq
    import i2cm_pkg::*;
#(
    parameter int AW     = 3,
    parameter int WD_W   = 16,
    parameter int RD_W   = 32,
    parameter int STS_W  = 15,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [WD_W-1:0]   reg_wdata,
    input  logic [AW-1:0]     rd_addr,
    output logic [RD_W-1:0]   rd_data,
    input  logic              bus_busy,
    output logic              txn_req,
    output logic [1:0]        txn_op,
    output logic [BYTE_W-1:0] txn_byte,
    output logic              txn_last,
    input  logic              txn_done,
    input  logic              txn_ack,
    input  logic [BYTE_W-1:0] txn_rdata,
    output logic              irq
);

    localparam int BUF_W  = 2 * BYTE_W;
    localparam int CMD_W  = WD_W;
    localparam int HI_PAD = RD_W - 23;

    logic [WD_W-1:0]  ctrl_q;
    logic [CMD_W-1:0] cmd_q;
    logic [BUF_W-1:0] buf_q;
    logic             wr_ctrl, wr_ien, wr_sts, wr_cmd, wr_buf, cmd_accept;
    logic [CB_W-1:0]  cmd_clr;
    logic [STS_W-1:0] sts_set, ien, status;
    logic             rx_load, seq_end, seq_idle;
    logic [3:0]       state_code;
    txn_op_e          op_e;

    assign wr_ctrl    = reg_we && (reg_addr == RA_CTRL);
    assign wr_ien     = reg_we && (reg_addr == RA_IEN);
    assign wr_sts     = reg_we && (reg_addr == RA_STS);
    assign wr_cmd     = reg_we && (reg_addr == RA_CMD);
    assign wr_buf     = reg_we && (reg_addr == RA_BUF);
    assign cmd_accept = wr_cmd && ctrl_q[0] && seq_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmd_q  <= '0;
            buf_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata;
            if (cmd_accept) begin
                cmd_q <= reg_wdata;
            end else begin
                cmd_q <= cmd_q & ~{{(CMD_W-CB_W){1'b0}}, cmd_clr};
            end
            if (wr_buf) begin
                buf_q[BYTE_W-1:0] <= reg_wdata[BYTE_W-1:0];
            end else if (rx_load) begin
                buf_q[BUF_W-1:BYTE_W] <= txn_rdata;
            end
        end
    end

    i2cm_seq_fsm #(.STS_W(STS_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (cmd_accept),
        .c_start      (cmd_q[CB_START]),
        .c_tx         (cmd_q[CB_TX]),
        .c_rx         (cmd_q[CB_RX]),
        .c_last       (cmd_q[CB_LAST]),
        .c_stop       (cmd_q[CB_STOP]),
        .rx_done_flag (status[ST_RXDONE]),
        .txn_done     (txn_done),
        .txn_ack      (txn_ack),
        .txn_req      (txn_req),
        .txn_op       (op_e),
        .cmd_clr      (cmd_clr),
        .sts_set      (sts_set),
        .rx_load      (rx_load),
        .seq_end      (seq_end),
        .seq_idle     (seq_idle),
        .state_code   (state_code)
    );

    i2cm_irq #(.STS_W(STS_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_we  (wr_ien),
        .sts_we  (wr_sts),
        .wdata   (reg_wdata[STS_W-1:0]),
        .sts_set (sts_set),
        .seq_end (seq_end),
        .ien     (ien),
        .status  (status),
        .irq     (irq)
    );

    assign txn_op   = op_e;
    assign txn_byte = buf_q[BYTE_W-1:0];
    assign txn_last = cmd_q[CB_LAST];

    always_comb begin
        unique case (rd_addr)
            RA_CTRL: rd_data = {{(RD_W-WD_W){1'b0}}, ctrl_q};
            RA_IEN:  rd_data = {{(RD_W-STS_W){1'b0}}, ien};
            RA_STS:  rd_data = {{(RD_W-STS_W){1'b0}}, status};
            RA_CMD:  rd_data = {{HI_PAD{1'b0}}, state_code, 2'b00, bus_busy, cmd_q};
            RA_BUF:  rd_data = {{(RD_W-BUF_W){1'b0}}, buf_q};
            default: rd_data = '0;
        endcase
    end

    // R1: a refused command write leaves the upper command bits untouched
    p_cmd_refused_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !ctrl_q[0]) |=> $stable(cmd_q[CMD_W-1:CB_W]));

    // R5: a loaded receive byte always comes with receive-done set
    p_rx_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && !wr_sts) |=> status[ST_RXDONE] || !ien[ST_RXDONE]);

endmodule

// File: tb/sim_i2cm_cmd_seq.sv
module sim_i2cm_cmd_seq;
    localparam int LOGN = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  rd_addr = 3'd3;
    logic [31:0] rd_data;
    logic        bus_busy = 1'b0;
    logic        txn_req, txn_last, irq;
    logic [1:0]  txn_op;
    logic [7:0]  txn_byte;
    logic        txn_done = 1'b0, txn_ack = 1'b0;
    logic [7:0]  txn_rdata = '0;

    int checks = 0, errors = 0, n_log = 0, mi = 0, chk_idx = 0;
    bit finished = 0;

    logic        plan_ack  [LOGN];
    logic [7:0]  plan_data [LOGN];
    logic [1:0]  lg_op [LOGN];   logic [7:0] lg_byte [LOGN];
    logic        lg_last [LOGN]; logic [3:0] lg_sc [LOGN];
    logic [1:0]  ex_op [LOGN];   logic [7:0] ex_byte [LOGN];
    logic        ex_last [LOGN]; logic [3:0] ex_sc [LOGN];

    // model state
    logic [15:0] m_ctrl = 0, m_cmd = 0, m_buf = 0;
    logic [14:0] m_ien = 0, m_sts = 0;
    logic [3:0]  m_sc = 0;
    logic        m_irq = 0;

    always #10 clk = ~clk;  // 50 MHz

    i2cm_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .bus_busy(bus_busy), .txn_req(txn_req), .txn_op(txn_op),
        .txn_byte(txn_byte), .txn_last(txn_last), .txn_done(txn_done),
        .txn_ack(txn_ack), .txn_rdata(txn_rdata), .irq(irq));

    // Transaction engine model: logs each step, answers from the plan
    initial begin
        forever begin
            @(negedge clk);
            if (txn_req && n_log < LOGN) begin
                lg_op[n_log] = txn_op;     lg_byte[n_log] = txn_byte;
                lg_last[n_log] = txn_last; lg_sc[n_log] = rd_data[22:19];
                repeat ($urandom_range(0, 3)) @(negedge clk);
                txn_ack = plan_ack[n_log];
                txn_rdata = plan_data[n_log];
                txn_done = 1'b1;
                n_log++;
                @(negedge clk);
                txn_done = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a; #1; d = rd_data;
        rd_addr = 3'd3;
    endtask

    task automatic expect_step(input logic [1:0] op, input logic [3:0] sc);
        ex_op[mi] = op; ex_byte[mi] = m_buf[7:0];
        ex_last[mi] = m_cmd[4]; ex_sc[mi] = sc;
        mi++;
    endtask

    // Model of the requirements R2..R8
    task automatic run_model();
        bit cont;
        do begin
            cont = 1;
            if (m_cmd[0]) begin                      // R3
                m_sc = m_sc[3] ? 4'hA : 4'h9;
                expect_step(2'd0, m_sc);
                if (plan_ack[mi-1]) begin
                    m_sts[0] = 1; m_cmd[1:0] = 0; m_sc = 4'h8;
                end else begin
                    m_sts[1] = 1; m_cmd[5:0] = 0; m_sc = 4'h0; cont = 0;
                end
            end
            if (cont && m_cmd[1]) begin              // R4
                expect_step(2'd1, 4'hC);
                if (plan_ack[mi-1]) m_sts[0] = 1; else m_sts[1] = 1;
                m_cmd[1] = 0; m_sc = 4'h8;
            end
            if (cont && (m_cmd[3] | m_cmd[4]) && !m_sts[2]) begin  // R5, R6
                expect_step(2'd2, 4'hE);
                m_buf[15:8] = plan_data[mi-1];
                m_sts[2] = 1; m_cmd[3] = 0; m_cmd[4] = 0; m_sc = 4'h8;
            end
            if (cont && m_cmd[5]) begin              // R7
                if (!m_sc[3]) m_sts[5] = 1;
                else begin expect_step(2'd3, 4'hB); m_sts[4] = 1; end
                m_sc = 4'h0; m_cmd[5] = 0;
            end
            m_sts = m_sts & m_ien;                   // R8
            m_irq = |m_sts;
        end while ((m_cmd[3] | m_cmd[4]) && !m_sts[2]);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        chk({tag, " R11 step count"}, n_log, mi);
        for (int i = chk_idx; i < n_log && i < mi; i++) begin
            chk({tag, " R2 step op"}, lg_op[i], ex_op[i]);
            chk({tag, " R3 step byte"}, lg_byte[i], ex_byte[i]);
            chk({tag, " R5 last flag"}, lg_last[i], ex_last[i]);
            chk({tag, " R10 state code in step"}, lg_sc[i], ex_sc[i]);
        end
        chk_idx = n_log; mi = n_log;
        reg_read(3'd3, d);
        chk({tag, " R1 command bits"}, d[15:0], m_cmd);
        chk({tag, " R10 state code"}, d[22:19], m_sc);
        chk({tag, " R10 busy bit"}, d[16], bus_busy);
        reg_read(3'd2, d);
        chk({tag, " R8 status"}, d, {17'b0, m_sts});
        reg_read(3'd4, d);
        chk({tag, " R5 buffer"}, d, {16'b0, m_buf});
        chk({tag, " R9 irq"}, irq, m_irq);
    endtask

    task automatic do_cmd(input string tag, input logic [15:0] c);
        reg_write(3'd3, c);
        if (m_ctrl[0]) begin m_cmd = c; run_model(); end
        repeat (50) @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_clear(input string tag, input logic [14:0] m);
        reg_write(3'd2, {1'b0, m});
        m_sts = m_sts & ~m;
        if (m_sts == 0) m_irq = 0;
        if ((m_cmd[3] | m_cmd[4]) && !m_sts[2]) run_model();
        repeat (50) @(negedge clk);
        check_all(tag);
    endtask

    task automatic set_ien(input logic [14:0] v);
        reg_write(3'd1, {1'b0, v}); m_ien = v;
    endtask

    task automatic set_buf(input logic [7:0] v);
        reg_write(3'd4, {8'h00, v}); m_buf[7:0] = v;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic [15:0] c;
        void'($urandom(32'd1234));
        for (int i = 0; i < LOGN; i++) begin
            plan_ack[i] = (i < 32) ? 1'b1 : ($urandom_range(0, 4) != 0);
            plan_data[i] = 8'($urandom);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset values
        for (int a = 0; a < 5; a++) begin
            reg_read(3'(a), d);
            chk("R12 reset register", d, 32'h0);
        end
        chk("R12 reset irq", irq, 1'b0);
        chk("R12 reset req", txn_req, 1'b0);

        // R1: master disabled, command refused
        set_ien(15'h7FFF);
        do_cmd("R1 disabled", 16'h0021);

        reg_write(3'd0, 16'h0001); m_ctrl = 16'h0001;
        reg_read(3'd0, d);
        chk("R10 control readback", d, 32'h1);

        // R7: STOP with no open transfer is abnormal
        do_cmd("R7 abnormal stop", 16'h0020);
        do_clear("R9 clear all", 15'h7FFF);

        // R3/R4: START+TX, then repeated START from active state
        set_buf(8'hA4);
        do_cmd("R3 start tx", 16'h0003);
        set_buf(8'h5B);
        do_cmd("R3 repeated start", 16'h0001);
        do_clear("R8 partial clear", 15'h0001);

        // R5/R6: receive, then a held receive released by the clear
        do_cmd("R5 rx", 16'h0008);
        do_cmd("R6 rx held", 16'h0018);
        do_clear("R6 rx released", 15'h0004);
        do_cmd("R7 normal stop", 16'h0020);
        do_clear("R9 clear", 15'h7FFF);

        // R3: START NAK skips TX, RX and STOP
        plan_ack[n_log] = 1'b0;
        set_buf(8'h33);
        do_cmd("R3 start nak", 16'h003B);
        do_clear("R9 clear nak", 15'h7FFF);

        // R8: receive-done masked off lets a held receive run at once
        set_ien(15'h7FFB);
        do_cmd("R8 masked rx a", 16'h0009);
        do_cmd("R8 masked rx b", 16'h0028);

        // Random mixes
        for (int it = 0; it < 60; it++) begin
            bus_busy = 1'($urandom);
            set_ien(($urandom_range(0, 3) == 0) ? 15'($urandom) & 15'h7FFB
                                                : 15'($urandom) | 15'h0004);
            set_buf(8'($urandom));
            c = {10'($urandom), 6'($urandom) & 6'h3B};
            do_cmd("R2 random", c);
            if ($urandom_range(0, 1) == 1) do_clear("R8 random clear", 15'($urandom));
        end
        summary();
    end
endmodule